// File: doc/BRIEF.md
# UART Register Bank and Interrupt Controller

This block is the software-visible register bank of a serial port, attached to a simple word-addressed bus with single-cycle write and combinational read. It holds the configuration registers: the infrared low-power divisor, the integer and fractional baud divisors, line control, control, FIFO level select and DMA control. It presents a flag word built from the status of the receive FIFO, which is a separate block, and returns eight fixed identification bytes from the top of a 4 KB window. It also holds the raw interrupt status and the interrupt mask, and it drives one interrupt line from the two.

A write to the data offset sends the low byte out as a transmit strobe and raises the transmit interrupt. A read of the data offset returns the receive FIFO's head word, asks the FIFO to pop, and latches the word's error bits into a receive-status register. The FIFO signals a reached fill level with a one-cycle pulse, which raises the receive interrupt. When the FIFO-enable bit of line control changes, the block pulses a flush request to the FIFO.

Top module: `uart_rf_top`

## Requirements
- R1: After reset, control reads 0x0300, FIFO level select reads 0x12, the flag word reads 0x90 while the FIFO reports empty and not full, every other register reads 0, and `irq` is low.
- R2: A write to word index 0 drives `tx_valid` high with `tx_byte` equal to the low write byte during that cycle, and sets raw status bit 5 (transmit) from the next cycle.
- R3: A write to word index 17 clears each raw status bit written as 1. If `rx_hit` arrives in the same cycle, raw bit 4 ends up set.
- R4: `irq` is high exactly when raw status AND mask is non-zero. Word index 16 reads that AND. A mask write takes effect on `irq` in the next cycle.
- R5: A read of word index 0 latches bits 11:8 of `rx_word` into the receive-status register at word index 1. Any write to word index 1 clears it.
- R6: The flag word at index 6 is bit 7 = 1, bit 6 = `rx_full`, bit 5 = 0, bit 4 = `rx_empty`, and 0 elsewhere. Writes to index 6 have no effect.
- R7: Word indices 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, and writes to them have no effect.
- R8: Unmapped indices, index 17, and any address with bits 1:0 non-zero read 0. Writes to them change no register.
- R9: The configuration registers keep only their field widths: infrared divisor 8 bits (index 8), integer baud 16 (9), fractional baud 6 (10), line control 8 (11), control 16 (12), level select 6 (13), mask 11 (14), DMA control 3 (18).
- R10: `fifo_en` equals line-control bit 4. A line-control write that changes bit 4 pulses `fifo_flush` in the write cycle, and a write that keeps bit 4 does not.
- R11: A read of index 0 returns `rx_word` zero-extended and pulses `rx_pop` only when `rx_empty` is low.
- R12: An `rx_hit` pulse sets raw status bit 4 (receive) from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; only side effects depend on it |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| rx_word | input | 12 | Receive FIFO head: error bits 11:8, byte 7:0 |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| rx_hit | input | 1 | Receive fill-level pulse |
| rx_pop | output | 1 | Pop request to the receive FIFO |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| fifo_en | output | 1 | FIFO mode from line control |
| fifo_flush | output | 1 | Flush request on FIFO-mode change |
| irq | output | 1 | Combined interrupt |

## Verification
The raw status register has two writers: the FIFO's `rx_hit` pulse and the bus clear write. Both act on bit 4 in the same clock. The bench drives a clear of bit 4 together with an `rx_hit` pulse in one cycle. It then reads raw status and expects bit 4 to be set, and a bound property checks the same outcome. Separately, every combination of raw bits 4 and 5 against every mask pair is swept, and `irq` and the masked-status read are compared with the arithmetic AND.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 16;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int IRQ_W   = 11;
    localparam int RX_W    = 12;
    localparam int RSR_W   = RX_W - 8;
    localparam int W_IRDA  = 8;
    localparam int W_IBAUD = 16;
    localparam int W_FBAUD = 6;
    localparam int W_LINE  = 8;
    localparam int W_CTRL  = 16;
    localparam int W_LEVEL = 6;
    localparam int W_DMA   = 3;

    localparam logic [IDX_W-1:0] IX_DATA  = 10'd0;
    localparam logic [IDX_W-1:0] IX_RSR   = 10'd1;
    localparam logic [IDX_W-1:0] IX_FLAG  = 10'd6;
    localparam logic [IDX_W-1:0] IX_IRDA  = 10'd8;
    localparam logic [IDX_W-1:0] IX_IBAUD = 10'd9;
    localparam logic [IDX_W-1:0] IX_FBAUD = 10'd10;
    localparam logic [IDX_W-1:0] IX_LINE  = 10'd11;
    localparam logic [IDX_W-1:0] IX_CTRL  = 10'd12;
    localparam logic [IDX_W-1:0] IX_LEVEL = 10'd13;
    localparam logic [IDX_W-1:0] IX_MASK  = 10'd14;
    localparam logic [IDX_W-1:0] IX_RAW   = 10'd15;
    localparam logic [IDX_W-1:0] IX_MSKD  = 10'd16;
    localparam logic [IDX_W-1:0] IX_CLR   = 10'd17;
    localparam logic [IDX_W-1:0] IX_DMA   = 10'd18;
    localparam logic [IDX_W-1:0] IX_ID0   = 10'h3F8;

    localparam int BIT_RXI   = 4;
    localparam int BIT_TXI   = 5;
    localparam int BIT_FIFOE = 4;

    localparam logic [W_CTRL-1:0]  CTRL_RST  = 16'h0300;
    localparam logic [W_LEVEL-1:0] LEVEL_RST = 6'h12;

    typedef struct packed {
        logic data;
        logic rsr;
        logic flag;
        logic irda;
        logic ibaud;
        logic fbaud;
        logic line;
        logic ctrl;
        logic level;
        logic mask;
        logic raw;
        logic mskd;
        logic clr;
        logic dma;
        logic id;
    } sel_t;

    typedef struct packed {
        logic [W_IRDA-1:0]  irda;
        logic [W_IBAUD-1:0] ibaud;
        logic [W_FBAUD-1:0] fbaud;
        logic [W_LINE-1:0]  line;
        logic [W_CTRL-1:0]  ctrl;
        logic [W_LEVEL-1:0] level;
        logic [W_DMA-1:0]   dma;
    } cfg_t;

    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0:    return 8'h11;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] flag_word(input logic full, input logic empty);
        logic [DATA_W-1:0] f;
        f    = '0;
        f[7] = 1'b1;
        f[6] = full;
        f[4] = empty;
        return f;
    endfunction
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output sel_t          sel
);
    localparam int IW = AW - 2;

    logic [IW-1:0] idx;
    logic          aligned;

    assign idx     = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        sel = '0;
        if (aligned) begin
            case (idx)
                IX_DATA:  sel.data  = 1'b1;
                IX_RSR:   sel.rsr   = 1'b1;
                IX_FLAG:  sel.flag  = 1'b1;
                IX_IRDA:  sel.irda  = 1'b1;
                IX_IBAUD: sel.ibaud = 1'b1;
                IX_FBAUD: sel.fbaud = 1'b1;
                IX_LINE:  sel.line  = 1'b1;
                IX_CTRL:  sel.ctrl  = 1'b1;
                IX_LEVEL: sel.level = 1'b1;
                IX_MASK:  sel.mask  = 1'b1;
                IX_RAW:   sel.raw   = 1'b1;
                IX_MSKD:  sel.mskd  = 1'b1;
                IX_CLR:   sel.clr   = 1'b1;
                IX_DMA:   sel.dma   = 1'b1;
                default:  sel       = '0;
            endcase
            sel.id = (idx[IW-1:3] == IX_ID0[IW-1:3]);
        end
    end
endmodule

// File: rtl/uart_rf_cfg.sv
module uart_rf_cfg
    import uart_rf_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  sel_t          sel,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{ctrl: CTRL_RST, level: LEVEL_RST, default: '0};
        end else if (wr) begin
            if (sel.irda)  cfg.irda  <= wdata[W_IRDA-1:0];
            if (sel.ibaud) cfg.ibaud <= wdata[W_IBAUD-1:0];
            if (sel.fbaud) cfg.fbaud <= wdata[W_FBAUD-1:0];
            if (sel.line)  cfg.line  <= wdata[W_LINE-1:0];
            if (sel.ctrl)  cfg.ctrl  <= wdata[W_CTRL-1:0];
            if (sel.level) cfg.level <= wdata[W_LEVEL-1:0];
            if (sel.dma)   cfg.dma   <= wdata[W_DMA-1:0];
        end
    end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq #(
    parameter int NB = uart_rf_pkg::IRQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mask_wr,
    input  logic [NB-1:0] mask_wdata,
    input  logic          clr_wr,
    input  logic [NB-1:0] clr_bits,
    input  logic [NB-1:0] set_bits,
    output logic [NB-1:0] raw,
    output logic [NB-1:0] mask,
    output logic [NB-1:0] masked,
    output logic          irq
);
    logic [NB-1:0] raw_nx;

    // per-bit update: a set event outranks a clear written in the same cycle
    for (genvar b = 0; b < NB; b++) begin : g_bit
        always_comb begin
            if (set_bits[b])
                raw_nx[b] = 1'b1;
            else if (clr_wr && clr_bits[b])
                raw_nx[b] = 1'b0;
            else
                raw_nx[b] = raw[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= raw_nx;
            if (mask_wr) mask <= mask_wdata;
        end
    end

    assign masked = raw & mask;
    assign irq    = |masked;
endmodule

// File: rtl/uart_rf_top.sv
module uart_rf_top
    import uart_rf_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int NB  = IRQ_W,
    parameter int RXW = RX_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [RXW-1:0] rx_word,
    input  logic           rx_empty,
    input  logic           rx_full,
    input  logic           rx_hit,
    output logic           rx_pop,
    output logic           tx_valid,
    output logic [7:0]     tx_byte,
    output logic           fifo_en,
    output logic           fifo_flush,
    output logic           irq
);
    localparam int SW = RXW - 8;

    sel_t          sel;
    cfg_t          cfg;
    logic [NB-1:0] raw_q;
    logic [NB-1:0] mask_q;
    logic [NB-1:0] masked;
    logic [NB-1:0] set_bits;
    logic [SW-1:0] rsr_q;
    logic          data_rd;

    uart_rf_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    uart_rf_cfg #(.DW(DW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    always_comb begin
        set_bits          = '0;
        set_bits[BIT_TXI] = bus_wr && sel.data;
        set_bits[BIT_RXI] = rx_hit;
    end

    uart_rf_irq #(.NB(NB)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .mask_wr    (bus_wr && sel.mask),
        .mask_wdata (bus_wdata[NB-1:0]),
        .clr_wr     (bus_wr && sel.clr),
        .clr_bits   (bus_wdata[NB-1:0]),
        .set_bits   (set_bits),
        .raw        (raw_q),
        .mask       (mask_q),
        .masked     (masked),
        .irq        (irq)
    );

    assign data_rd = bus_rd && sel.data;

    always_ff @(posedge clk) begin
        if (rst)
            rsr_q <= '0;
        else if (data_rd)
            rsr_q <= rx_word[RXW-1:8];
        else if (bus_wr && sel.rsr)
            rsr_q <= '0;
    end

    assign rx_pop     = data_rd && !rx_empty;
    assign tx_valid   = bus_wr && sel.data;
    assign tx_byte    = bus_wdata[7:0];
    assign fifo_en    = cfg.line[BIT_FIFOE];
    assign fifo_flush = bus_wr && sel.line && (bus_wdata[BIT_FIFOE] != cfg.line[BIT_FIFOE]);

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            sel.data:  bus_rdata = DW'(rx_word);
            sel.rsr:   bus_rdata = DW'(rsr_q);
            sel.flag:  bus_rdata = flag_word(rx_full, rx_empty);
            sel.irda:  bus_rdata = DW'(cfg.irda);
            sel.ibaud: bus_rdata = DW'(cfg.ibaud);
            sel.fbaud: bus_rdata = DW'(cfg.fbaud);
            sel.line:  bus_rdata = DW'(cfg.line);
            sel.ctrl:  bus_rdata = DW'(cfg.ctrl);
            sel.level: bus_rdata = DW'(cfg.level);
            sel.mask:  bus_rdata = DW'(mask_q);
            sel.raw:   bus_rdata = DW'(raw_q);
            sel.mskd:  bus_rdata = DW'(masked);
            sel.dma:   bus_rdata = DW'(cfg.dma);
            sel.id:    bus_rdata = DW'(id_byte(bus_addr[4:2]));
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_rf_chk.sv
module uart_rf_chk
    import uart_rf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rx_empty,
    input logic              rx_hit,
    input logic              rx_pop,
    input logic              fifo_flush,
    input logic              irq,
    input logic [IRQ_W-1:0]  raw,
    input logic [RSR_W-1:0]  rsr
);
    logic at_data, at_rsr, at_line, at_mask, at_clr;
    assign at_data = bus_addr == {IX_DATA, 2'b00};
    assign at_rsr  = bus_addr == {IX_RSR,  2'b00};
    assign at_line = bus_addr == {IX_LINE, 2'b00};
    assign at_mask = bus_addr == {IX_MASK, 2'b00};
    assign at_clr  = bus_addr == {IX_CLR,  2'b00};

    assert_tx_sets_raw_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && at_data) |=> raw[BIT_TXI]);

    assert_clear_tx_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && at_clr && bus_wdata[BIT_TXI]) |=> !raw[BIT_TXI]);

    assert_set_beats_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && at_clr && bus_wdata[BIT_RXI] && rx_hit) |=> raw[BIT_RXI]);

    assert_mask_zero_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && at_mask && bus_wdata[IRQ_W-1:0] == '0) |=> !irq);

    assert_rsr_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && at_rsr) |=> (rsr == '0));

    assert_flush_on_line_write_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> (bus_wr && at_line));

    assert_no_pop_when_empty_R11: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> !rx_empty);

    assert_hit_sets_raw_R12: assert property (@(posedge clk) disable iff (rst)
        rx_hit |=> raw[BIT_RXI]);
endmodule

bind uart_rf_top uart_rf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rx_empty   (rx_empty),
    .rx_hit     (rx_hit),
    .rx_pop     (rx_pop),
    .fifo_flush (fifo_flush),
    .irq        (irq),
    .raw        (raw_q),
    .rsr        (rsr_q)
);

// File: tb/uart_rf_top_test.sv
module uart_rf_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [11:0] rx_word = '0;
    logic        rx_empty = 1'b1;
    logic        rx_full = 1'b0;
    logic        rx_hit = 1'b0;
    logic        rx_pop, tx_valid, fifo_en, fifo_flush, irq;
    logic [7:0]  tx_byte;

    int checks = 0;
    int errors = 0;

    // bench-side model of the register contents
    logic [7:0]  m_irda, m_line;
    logic [15:0] m_ibaud, m_ctrl;
    logic [5:0]  m_fbaud, m_level;
    logic [2:0]  m_dma;
    logic [10:0] m_raw, m_mask;
    logic [3:0]  m_rsr;

    always #4 clk = ~clk;

    uart_rf_top uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_word(rx_word), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_hit(rx_hit), .rx_pop(rx_pop), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .fifo_en(fifo_en), .fifo_flush(fifo_flush),
        .irq(irq)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_id(input int k);
        case (k)
            0: return 8'h11; 1: return 8'h10; 2: return 8'h14; 3: return 8'h00;
            4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
        endcase
    endfunction

    function automatic logic [15:0] model_read(input int idx);
        case (idx)
            0:  return {4'h0, rx_word};
            1:  return {12'h0, m_rsr};
            6:  return 16'h0080 | (16'(rx_full) << 6) | (16'(rx_empty) << 4);
            8:  return {8'h0, m_irda};
            9:  return m_ibaud;
            10: return {10'h0, m_fbaud};
            11: return {8'h0, m_line};
            12: return m_ctrl;
            13: return {10'h0, m_level};
            14: return {5'h0, m_mask};
            15: return {5'h0, m_raw};
            16: return {5'h0, m_raw & m_mask};
            18: return {13'h0, m_dma};
            default: return (idx >= 'h3F8) ? {8'h0, exp_id(idx - 'h3F8)} : 16'h0;
        endcase
    endfunction

    task automatic model_write(input int idx, input logic [15:0] d);
        case (idx)
            0:  m_raw[5] = 1'b1;
            1:  m_rsr = '0;
            8:  m_irda = d[7:0];
            9:  m_ibaud = d;
            10: m_fbaud = d[5:0];
            11: m_line = d[7:0];
            12: m_ctrl = d;
            13: m_level = d[5:0];
            14: m_mask = d[10:0];
            17: m_raw = m_raw & ~d[10:0];
            18: m_dma = d[2:0];
            default: ;
        endcase
    endtask

    task automatic wr(input int idx, input logic [15:0] d);
        @(negedge clk);
        bus_addr = 12'(idx << 2); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        model_write(idx, d);
    endtask

    task automatic rd_chk(input int idx, input string tag);
        logic [15:0] e;
        @(negedge clk);
        bus_addr = 12'(idx << 2); #1;
        e = model_read(idx);
        chk(bus_rdata == e, tag, bus_rdata, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_irda = 0; m_ibaud = 0; m_fbaud = 0; m_line = 0; m_ctrl = 16'h0300;
        m_level = 6'h12; m_dma = 0; m_raw = 0; m_mask = 0; m_rsr = 0;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;

        // R1, R7, R8: every word index after reset
        for (int i = 0; i < 1024; i++) rd_chk(i, "R1/R7/R8 reset sweep");
        @(negedge clk); #1;
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);

        // R8: misaligned address reads zero
        @(negedge clk); bus_addr = 12'h031; #1;
        chk(bus_rdata == 16'h0, "R8 misaligned read", bus_rdata, 0);

        // R9, R6, R7, R8: write all ones everywhere, then read everything back
        for (int i = 0; i < 1024; i++) wr(i, 16'hFFFF);
        for (int i = 0; i < 1024; i++) rd_chk(i, "R9/R6/R7/R8 write sweep");

        // R10: bit 4 change pulses flush, no change does not
        @(negedge clk);
        bus_addr = 12'(11 << 2); bus_wdata = 16'h0000; bus_wr = 1'b1; #1;
        chk(fifo_flush == 1'b1, "R10 flush on change", fifo_flush, 1);
        @(posedge clk); #1; bus_wr = 1'b0; model_write(11, 16'h0000);
        @(negedge clk);
        chk(fifo_en == 1'b0, "R10 fifo_en follows line bit4", fifo_en, 0);
        bus_addr = 12'(11 << 2); bus_wdata = 16'h000F; bus_wr = 1'b1; #1;
        chk(fifo_flush == 1'b0, "R10 no flush without change", fifo_flush, 0);
        @(posedge clk); #1; bus_wr = 1'b0; model_write(11, 16'h000F);
        wr(11, 16'h0010);
        @(negedge clk); #1;
        chk(fifo_en == 1'b1, "R10 fifo_en set", fifo_en, 1);

        // R2: transmit strobe and raw transmit bit
        @(negedge clk);
        bus_addr = 12'h000; bus_wdata = 16'h01A5; bus_wr = 1'b1; #1;
        chk(tx_valid == 1'b1, "R2 tx_valid", tx_valid, 1);
        chk(tx_byte == 8'hA5, "R2 tx_byte", tx_byte, 8'hA5);
        @(posedge clk); #1; bus_wr = 1'b0; model_write(0, 16'h01A5);
        rd_chk(15, "R2 raw after data write");

        // R3: clear of bit 4 together with rx_hit leaves bit 4 set
        @(negedge clk);
        bus_addr = 12'(17 << 2); bus_wdata = 16'h0010; bus_wr = 1'b1; rx_hit = 1'b1;
        @(posedge clk); #1; bus_wr = 1'b0; rx_hit = 1'b0;
        m_raw[4] = 1'b1;
        rd_chk(15, "R3 set beats clear");
        wr(17, 16'h0030);
        rd_chk(15, "R3 clear both bits");

        // R4, R12: sweep raw bits 4/5 against mask bits 4/5
        for (int r = 0; r < 4; r++) begin
            for (int m = 0; m < 4; m++) begin
                wr(17, 16'h07FF);
                if (r[1]) wr(0, 16'h0000);
                if (r[0]) begin
                    @(negedge clk); rx_hit = 1'b1;
                    @(posedge clk); #1; rx_hit = 1'b0; m_raw[4] = 1'b1;
                end
                wr(14, 16'(m << 4));
                @(negedge clk); #1;
                chk(irq == ((r & m) != 0), "R4 irq vs raw&mask", irq, int'((r & m) != 0));
                rd_chk(16, "R4 masked read");
                rd_chk(15, "R12 raw receive bit");
            end
        end

        // R11, R5: data read with a non-empty FIFO
        rx_word = 12'h5A3; rx_empty = 1'b0;
        @(negedge clk);
        bus_addr = 12'h000; bus_rd = 1'b1; #1;
        chk(bus_rdata == 16'h05A3, "R11 data read value", bus_rdata, 16'h05A3);
        chk(rx_pop == 1'b1, "R11 pop when not empty", rx_pop, 1);
        @(posedge clk); #1; bus_rd = 1'b0; m_rsr = 4'h5;
        rd_chk(1, "R5 status latched");
        wr(1, 16'h0000);
        rd_chk(1, "R5 status cleared");
        rx_empty = 1'b1;
        @(negedge clk);
        bus_addr = 12'h000; bus_rd = 1'b1; #1;
        chk(rx_pop == 1'b0, "R11 no pop when empty", rx_pop, 0);
        @(posedge clk); #1; bus_rd = 1'b0; m_rsr = 4'h5;
        rd_chk(1, "R5 status latched on empty read");

        // R6: flags follow FIFO status, writes ignored
        rx_full = 1'b1; rx_empty = 1'b0;
        wr(6, 16'h0000);
        rd_chk(6, "R6 flags full");
        @(negedge clk); #1;
        chk(bus_rdata == 16'h00C0, "R6 flags value", bus_rdata, 16'h00C0);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule